// File: doc/BRIEF.md
# Reset Sequencer with Source Flags

This block produces the active-low system reset for a small microcontroller and remembers why the last reset happened. It watches a clean, already synchronous supply-good level, an asynchronous external reset request and a software write port. While the supply is bad, the reset output stays asserted. Once the supply is good, the output stays asserted for a fixed power-on delay, given as a parameter in clock cycles; the default matches about 0.3 ms at 50 MHz.

An external request passes through a two-flop synchroniser and produces a short reset pulse. Software can force a reset that behaves exactly like a power-on reset by writing the force bit of the source register. The source register shows a power-on flag and an external flag. While the power-on flag is set, the other flags have no defined meaning. The block also drives a supply-monitor enable, which is set by the first completed power-on sequence, and a constant start-address output.

Top module: `rst_seq_top`

## Requirements
- R1: While `supply_ok` is 0, `rst_n_out` is 0 from the next clock edge onward.
- R2: After `supply_ok` rises, `rst_n_out` stays low for exactly POR_CYCLES cycles, starting at the first edge that samples `supply_ok` high. It then goes high and remains high.
- R3: After a power-on sequence, bit 1 of `src_reg` (the power-on flag) reads 1.
- R4: An external request held high for W cycles is seen through two flops. `rst_n_out` goes low at the third edge after the request rises and stays low for W+EXT_CYCLES-1 cycles. Afterwards `src_reg` reads 8'h01: bit 0 (external flag) is 1 and bit 1 is cleared.
- R5: A write while running, with bit 4 of `sw_wr_data` set, makes `rst_n_out` low from the next edge for exactly POR_CYCLES cycles. Afterwards `src_reg` bit 1 reads 1.
- R6: A write with bit 4 clear starts no reset and leaves `src_reg` unchanged. Bit 4 and bits 7:2 of `src_reg` always read 0.
- R7: A drop of `supply_ok` at any point of the power-on delay restarts the sequence, so the full POR_CYCLES delay follows the next rise.
- R8: `reset_vector` is always 16'h0000.
- R9: `mon_en` is 0 after the block's own reset and becomes 1 when a power-on delay completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer itself |
| supply_ok | input | 1 | Supply above threshold, clean synchronous level |
| ext_rst_req | input | 1 | Asynchronous external reset request, active high |
| sw_wr_en | input | 1 | Software write strobe to the source register |
| sw_wr_data | input | 8 | Software write data; bit 4 forces a power-on reset |
| rst_n_out | output | 1 | System reset, active low |
| src_reg | output | 8 | Reset source register read value |
| mon_en | output | 1 | Supply-monitor enable |
| reset_vector | output | 16 | Start address after any reset |

## Verification
The assertions assume that `supply_ok` is already synchronous to `clk` and free of glitches. They also assume that a software write is meaningful only while `rst_n_out` is high. The bench changes every input just after a falling edge and holds it for whole cycles. It issues writes only when the sequencer is running, and it checks the external flag only after an external reset, when the power-on flag is known to be clear.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    localparam int SRC_W     = 8;
    localparam int EXT_BIT   = 0;
    localparam int POR_BIT   = 1;
    localparam int FORCE_BIT = 4;

    typedef enum logic [1:0] {
        ST_LOW = 2'd0,
        ST_POR = 2'd1,
        ST_EXT = 2'd2,
        ST_RUN = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        EV_NONE     = 2'd0,
        EV_POWER    = 2'd1,
        EV_EXT      = 2'd2,
        EV_POR_DONE = 2'd3
    } seq_evt_t;

    typedef struct packed {
        logic por;
        logic ext;
    } src_flags_t;

    function automatic logic [SRC_W-1:0] pack_src(src_flags_t f);
        logic [SRC_W-1:0] v;
        v          = '0;
        v[POR_BIT] = f.por;
        v[EXT_BIT] = f.ext;
        return v;
    endfunction

endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import rst_seq_pkg::*;
#(
    parameter int POR_CYCLES = 15000,
    parameter int EXT_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_ok,
    input  logic       ext_req,
    input  logic       force_req,
    output seq_state_t state,
    output seq_evt_t   evt
);
    localparam int MAXC  = (POR_CYCLES > EXT_CYCLES) ? POR_CYCLES : EXT_CYCLES;
    localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC + 1) : 1;
    localparam logic [CNT_W-1:0] POR_LAST = CNT_W'(POR_CYCLES - 1);
    localparam logic [CNT_W-1:0] EXT_LAST = CNT_W'(EXT_CYCLES - 1);

    seq_state_t       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        evt   = EV_NONE;
        if (!supply_ok) begin
            st_d  = ST_LOW;
            cnt_d = '0;
            evt   = EV_POWER;
        end else begin
            unique case (st_q)
                ST_LOW: begin
                    st_d  = ST_POR;
                    cnt_d = '0;
                end
                ST_POR: begin
                    if (cnt_q == POR_LAST) begin
                        st_d  = ST_RUN;
                        cnt_d = '0;
                        evt   = EV_POR_DONE;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                ST_EXT: begin
                    if (ext_req) begin
                        cnt_d = '0;
                    end else if (cnt_q == EXT_LAST) begin
                        st_d  = ST_RUN;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                ST_RUN: begin
                    if (force_req) begin
                        st_d  = ST_POR;
                        cnt_d = '0;
                        evt   = EV_POWER;
                    end else if (ext_req) begin
                        st_d  = ST_EXT;
                        cnt_d = '0;
                        evt   = EV_EXT;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_LOW;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign state = st_q;
endmodule

// File: rtl/rst_seq_srcreg.sv
module rst_seq_srcreg
    import rst_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  seq_evt_t         evt,
    output logic [SRC_W-1:0] src_out,
    output logic             mon_en
);
    src_flags_t flags_q;
    logic       mon_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '{por: 1'b1, ext: 1'b0};
            mon_q   <= 1'b0;
        end else begin
            unique case (evt)
                EV_POWER:    flags_q.por <= 1'b1;
                EV_EXT:      flags_q     <= '{por: 1'b0, ext: 1'b1};
                EV_POR_DONE: mon_q       <= 1'b1;
                EV_NONE:     ;
            endcase
        end
    end

    assign src_out = pack_src(flags_q);
    assign mon_en  = mon_q;
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
    import rst_seq_pkg::*;
#(
    parameter int POR_CYCLES  = 15000,
    parameter int EXT_CYCLES  = 4,
    parameter int SYNC_STAGES = 2,
    parameter int VEC_W       = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             supply_ok,
    input  logic             ext_rst_req,
    input  logic             sw_wr_en,
    input  logic [SRC_W-1:0] sw_wr_data,
    output logic             rst_n_out,
    output logic [SRC_W-1:0] src_reg,
    output logic             mon_en,
    output logic [VEC_W-1:0] reset_vector
);
    logic       ext_sync;
    logic       force_req;
    seq_state_t state;
    seq_evt_t   evt;
    logic       wr_unused;

    assign force_req = sw_wr_en && sw_wr_data[FORCE_BIT];
    assign wr_unused = ^sw_wr_data;

    rst_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (ext_rst_req),
        .q_sync  (ext_sync)
    );

    rst_seq_fsm #(
        .POR_CYCLES (POR_CYCLES),
        .EXT_CYCLES (EXT_CYCLES)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (supply_ok),
        .ext_req   (ext_sync),
        .force_req (force_req),
        .state     (state),
        .evt       (evt)
    );

    rst_seq_srcreg u_src (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .src_out (src_reg),
        .mon_en  (mon_en)
    );

    assign rst_n_out    = (state == ST_RUN);
    assign reset_vector = '0;
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk
    import rst_seq_pkg::*;
#(
    parameter int VEC_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             supply_ok,
    input logic             ext_sync,
    input logic             sw_wr_en,
    input logic [SRC_W-1:0] sw_wr_data,
    input logic             rst_n_out,
    input logic [SRC_W-1:0] src_reg,
    input logic             mon_en,
    input logic [VEC_W-1:0] reset_vector
);
    // R1
    supply_low_holds_chk: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> !rst_n_out);

    // R2
    release_needs_supply_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_n_out) |-> $past(supply_ok));

    // R4
    ext_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (rst_n_out && supply_ok && ext_sync && !(sw_wr_en && sw_wr_data[FORCE_BIT]))
        |=> (!rst_n_out && src_reg[EXT_BIT] && !src_reg[POR_BIT]));

    // R5
    force_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (rst_n_out && sw_wr_en && sw_wr_data[FORCE_BIT])
        |=> (!rst_n_out && src_reg[POR_BIT]));

    // R6
    force_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        src_reg[FORCE_BIT] == 1'b0 && src_reg[SRC_W-1:2] == '0);

    // R8
    vector_zero_chk: assert property (@(posedge clk) disable iff (rst)
        reset_vector == '0);

    // R9
    mon_after_por_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(rst_n_out) && src_reg[POR_BIT]) |-> mon_en);
endmodule

bind rst_seq_top rst_seq_chk #(.VEC_W(VEC_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .supply_ok    (supply_ok),
    .ext_sync     (ext_sync),
    .sw_wr_en     (sw_wr_en),
    .sw_wr_data   (sw_wr_data),
    .rst_n_out    (rst_n_out),
    .src_reg      (src_reg),
    .mon_en       (mon_en),
    .reset_vector (reset_vector)
);

// File: tb/sim_rst_seq_top.sv
module sim_rst_seq_top;
    localparam int N = 8;
    localparam int M = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic        supply_ok;
    logic        ext_rst_req;
    logic        sw_wr_en;
    logic [7:0]  sw_wr_data;
    logic        rst_n_out;
    logic [7:0]  src_reg;
    logic        mon_en;
    logic [15:0] reset_vector;

    int vectors = 0;
    int miscmp  = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    rst_seq_top #(.POR_CYCLES(N), .EXT_CYCLES(M)) u0 (
        .clk          (clk),
        .rst          (rst),
        .supply_ok    (supply_ok),
        .ext_rst_req  (ext_rst_req),
        .sw_wr_en     (sw_wr_en),
        .sw_wr_data   (sw_wr_data),
        .rst_n_out    (rst_n_out),
        .src_reg      (src_reg),
        .mon_en       (mon_en),
        .reset_vector (reset_vector)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        vectors++;
        if (!ok) begin
            miscmp++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    endtask

    task automatic win_ext(int w, int win, output int lows);
        lows = 0;
        for (int i = 0; i < win; i++) begin
            ext_rst_req = (i < w);
            @(posedge clk); @(negedge clk);
            if (!rst_n_out) lows++;
        end
        ext_rst_req = 1'b0;
    endtask

    task automatic win_wr(logic [7:0] d, int win, output int lows);
        lows = 0;
        for (int i = 0; i < win; i++) begin
            sw_wr_en   = (i == 0);
            sw_wr_data = (i == 0) ? d : 8'h00;
            @(posedge clk); @(negedge clk);
            if (!rst_n_out) lows++;
        end
        sw_wr_en = 1'b0;
    endtask

    task automatic win_sup(int drop, int win, output int lows);
        lows = 0;
        for (int i = 0; i < win; i++) begin
            supply_ok = !(i == 0 || i == drop);
            @(posedge clk); @(negedge clk);
            if (!rst_n_out) lows++;
        end
        supply_ok = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscmp++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int lows;
        rst = 1'b1; supply_ok = 1'b0; ext_rst_req = 1'b0;
        sw_wr_en = 1'b0; sw_wr_data = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); @(negedge clk);
        // reset state
        chk(rst_n_out == 1'b0, "R1 reset-state rst_n", rst_n_out, 0);
        chk(src_reg == 8'h02, "R3 reset-state src", src_reg, 8'h02);
        chk(mon_en == 1'b0, "R9 reset-state mon_en", mon_en, 0);
        chk(reset_vector == 16'h0, "R8 vector", reset_vector, 0);
        repeat (5) @(negedge clk);
        chk(rst_n_out == 1'b0, "R1 supply held low", rst_n_out, 0);

        // first power-up: R2, R3, R9
        lows = 0;
        supply_ok = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); @(negedge clk);
            if (!rst_n_out) lows++;
        end
        chk(lows == N, "R2 power-on delay", lows, N);
        chk(rst_n_out == 1'b1, "R2 released", rst_n_out, 1);
        chk(src_reg[1] == 1'b1, "R3 por flag", src_reg, 8'h02);
        chk(mon_en == 1'b1, "R9 mon_en set", mon_en, 1);

        // external pulse widths: R4
        for (int w = 1; w <= 5; w++) begin
            win_ext(w, 25, lows);
            chk(lows == w + M - 1, "R4 ext pulse length", lows, w + M - 1);
            chk(src_reg == 8'h01, "R4 ext source", src_reg, 8'h01);
            chk(reset_vector == 16'h0, "R8 vector", reset_vector, 0);
        end

        // every write value: R5, R6
        for (int d = 0; d < 256; d++) begin
            win_ext(1, 12, lows);
            chk(src_reg == 8'h01, "R4 ext source before write", src_reg, 8'h01);
            win_wr(8'(d), 16, lows);
            if (d[4]) begin
                chk(lows == N, "R5 forced delay", lows, N);
                chk(src_reg[1] == 1'b1, "R5 forced por flag", src_reg, 8'h02);
                chk(src_reg[4] == 1'b0, "R6 force bit reads 0", src_reg, 8'h02);
            end else begin
                chk(lows == 0, "R6 write no reset", lows, 0);
                chk(src_reg == 8'h01, "R6 write no change", src_reg, 8'h01);
            end
            chk(rst_n_out == 1'b1, "R5 running after write", rst_n_out, 1);
        end

        // supply drop at each delay offset: R7, R1
        for (int dr = 2; dr <= N + 1; dr++) begin
            win_sup(dr, 40, lows);
            chk(lows == dr + N + 1, "R7 restart on drop", lows, dr + N + 1);
            chk(src_reg[1] == 1'b1, "R7 por flag", src_reg, 8'h02);
            chk(rst_n_out == 1'b1, "R7 released", rst_n_out, 1);
        end
        chk(mon_en == 1'b1, "R9 mon_en kept", mon_en, 1);
        chk(reset_vector == 16'h0, "R8 vector final", reset_vector, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule